// File: doc/BRIEF.md
# Micro-op decoupling queue

This block buffers decoded instructions between the decoder and the dispatch stage. It is a circular array of slots. Each instruction takes as many slots as it has micro-ops, so the queue capacity is measured in micro-ops rather than in instructions. Up to `LANES` instructions arrive per cycle. They are accepted strictly in program order, as long as there is room for them and the optional per-cycle intake cap allows. On the far side, up to `LANES` instructions are shown from the head of the queue. The dispatch stage returns how many of those leading instructions it takes.

The `delay_mode` input selects one of two drain timings. With `delay_mode` low the queue is transparent: an instruction accepted in a cycle can appear on the output behind the stored ones and leave in that same cycle. Slots freed by this cycle's drain cannot be reused until the next cycle. With `delay_mode` high, only stored instructions are shown, which adds one cycle of latency. Slots freed by the drain are available to intake in the same cycle.

A small occupancy state machine tracks the fill level. Its states are `FILL_EMPTY` (all slots free), `FILL_PART` (some slots used) and `FILL_FULL` (no slot free). On every clock edge it moves to the state that matches the next free-slot count. Any transition between the three states is possible, including `FILL_EMPTY` to `FILL_FULL` when one oversized instruction arrives, and `FILL_FULL` to `FILL_EMPTY` when everything drains at once. The pending-work flag `busy` is high in `FILL_PART` and `FILL_FULL`.

Top module: `uop_queue`

## Requirements
- R1: A synchronous reset empties the queue: `free_slots` equals the slot count, `busy` is low, and no output lane is valid while no input is offered.
- R2: The slot cost of an instruction is its micro-op count, clamped to the slot count. A count of zero costs one slot. `out_uops` reports this normalized cost.
- R3: Input lanes are considered from lane 0 upward. Lane k uses bits [k*TAG_W +: TAG_W] of `in_tag` and [k*UOP_W +: UOP_W] of `in_uops`. A lane is accepted only if all lower lanes were accepted, it is valid, and its cost is at most the slots still available. `in_taken` gives the number of leading lanes accepted.
- R4: When `intake_cap` is nonzero, at most that many instructions are accepted in a cycle. When it is zero, there is no cap.
- R5: Each cycle, `free_slots` drops by the cost of the accepted instructions and rises by the cost of the drained ones. It never exceeds the slot count.
- R6: `out_valid` marks a leading run of lanes holding the oldest instructions in queue order. `out_tag` and `out_uops` follow the lane layout of R3. The leading `out_take` lanes leave the queue. Any excess of `out_take` over the number of valid lanes is ignored.
- R7: With `delay_mode` low, accepted instructions appear on output lanes after the stored ones in the same cycle and may leave in that cycle. Intake sees only the free slots held at the start of the cycle.
- R8: With `delay_mode` high, the output shows only stored instructions, so an instruction accepted in a cycle appears no earlier than the next cycle. Slots drained in a cycle add to the space available for intake in that cycle.
- R9: `busy` is high exactly when `free_slots` differs from the slot count.
- R10: A configured depth of zero behaves as a one-slot queue. It accepts at most one instruction per cycle, whatever that instruction's micro-op count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| delay_mode | input | 1 | 0: zero-latency drain, 1: one-cycle-delay drain |
| intake_cap | input | $clog2(LANES+1) | Maximum instructions accepted per cycle, 0 means no limit |
| in_valid | input | LANES | Offered instruction per lane |
| in_tag | input | LANES*TAG_W | Instruction tags per lane |
| in_uops | input | LANES*UOP_W | Micro-op counts per lane |
| in_taken | output | $clog2(LANES+1) | Number of leading lanes accepted |
| out_valid | output | LANES | Head instructions presented |
| out_tag | output | LANES*TAG_W | Tags of presented instructions |
| out_uops | output | LANES*$clog2(SLOTS+1) | Normalized slot cost of presented instructions |
| out_take | input | $clog2(LANES+1) | Number of leading presented instructions taken downstream |
| free_slots | output | $clog2(SLOTS+1) | Free slot count |
| busy | output | 1 | Queue holds at least one instruction |

## Verification
The hardest cases to reach are the two drain timings colliding with a full queue. The bench has to check that zero-latency mode refuses an instruction even though the same cycle drains the whole queue. It also has to check that delay mode reuses slots freed by the same cycle's drain. The stimulus first fills the queue to exactly zero free slots with mixed one- and two-slot instructions, then drains and offers in one cycle under each mode. It also uses an oversized instruction that alone takes every slot.

// File: rtl/uq_pkg.sv
package uq_pkg;
    typedef enum logic [1:0] {
        FILL_EMPTY,
        FILL_PART,
        FILL_FULL
    } fill_e;
endpackage

// File: rtl/uq_intake.sv
module uq_intake #(
    parameter int LANES = 4,
    parameter int UOP_W = 4,
    parameter int SLOTS = 8,
    parameter int CW    = 4,
    parameter int LCW   = 3
) (
    input  logic [LANES-1:0]       lane_vld,
    input  logic [LANES*UOP_W-1:0] lane_uops,
    input  logic [LCW-1:0]         cap,
    input  logic [CW-1:0]          avail,
    output logic [LANES*CW-1:0]    lane_norm,
    output logic [LCW-1:0]         acc_n,
    output logic [CW-1:0]          acc_slots
);
    function automatic logic [CW-1:0] slot_cost(input logic [UOP_W-1:0] u);
        int v;
        v = int'(u);
        if (v == 0) v = 1;
        else if (v > SLOTS) v = SLOTS;
        return CW'(v);
    endfunction

    logic [CW-1:0] rem;
    logic [CW-1:0] nk;
    logic          run;

    always_comb begin
        lane_norm = '0;
        acc_n     = '0;
        acc_slots = '0;
        rem       = avail;
        run       = 1'b1;
        nk        = '0;
        for (int k = 0; k < LANES; k++) begin
            nk = slot_cost(lane_uops[k*UOP_W +: UOP_W]);
            lane_norm[k*CW +: CW] = nk;
            if (run && lane_vld[k] && (cap == '0 || k < int'(cap)) && nk <= rem) begin
                rem       = rem - nk;
                acc_n     = acc_n + LCW'(1);
                acc_slots = acc_slots + nk;
            end else begin
                run = 1'b0;
            end
        end
    end
endmodule

// File: rtl/uq_store.sv
module uq_store #(
    parameter int SLOTS = 8,
    parameter int TAG_W = 8,
    parameter int LANES = 4,
    parameter int CW    = 4,
    parameter int LCW   = 3,
    parameter int PW    = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [LCW-1:0]         wr_n,
    input  logic [LANES*TAG_W-1:0] wr_tag,
    input  logic [LANES*CW-1:0]    wr_norm,
    input  logic [CW-1:0]          wr_slots,
    input  logic [LCW-1:0]         rd_n,
    input  logic [CW-1:0]          rd_slots,
    output logic [LANES*TAG_W-1:0] st_tag,
    output logic [LANES*CW-1:0]    st_norm,
    output logic [LCW-1:0]         st_n,
    output logic [CW-1:0]          free
);
    function automatic logic [PW-1:0] adv(input logic [PW-1:0] p, input logic [CW-1:0] n);
        int s;
        s = int'(p) + int'(n);
        if (s >= SLOTS) s = s - SLOTS;
        return PW'(s);
    endfunction

    logic [TAG_W-1:0] mem_tag  [SLOTS];
    logic [CW-1:0]    mem_norm [SLOTS];
    logic [PW-1:0]    head, tail;
    logic [CW-1:0]    occ;
    logic [PW-1:0]    rd_p, wr_p;
    logic [PW-1:0]    wr_idx [LANES];

    // walk from the head over the stored instructions
    always_comb begin
        rd_p    = head;
        st_tag  = '0;
        st_norm = '0;
        for (int k = 0; k < LANES; k++) begin
            st_tag[k*TAG_W +: TAG_W] = mem_tag[rd_p];
            st_norm[k*CW +: CW]      = mem_norm[rd_p];
            rd_p = adv(rd_p, mem_norm[rd_p]);
        end
        st_n = (int'(occ) < LANES) ? LCW'(occ) : LCW'(LANES);
    end

    // write positions for the accepted lanes
    always_comb begin
        wr_p = tail;
        for (int k = 0; k < LANES; k++) begin
            wr_idx[k] = wr_p;
            wr_p = adv(wr_p, wr_norm[k*CW +: CW]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SLOTS; i++) begin
                mem_tag[i]  <= '0;
                mem_norm[i] <= CW'(1);
            end
            head <= '0;
            tail <= '0;
            occ  <= '0;
            free <= CW'(SLOTS);
        end else begin
            for (int k = 0; k < LANES; k++) begin
                if (k < int'(wr_n)) begin
                    mem_tag[wr_idx[k]]  <= wr_tag[k*TAG_W +: TAG_W];
                    mem_norm[wr_idx[k]] <= wr_norm[k*CW +: CW];
                end
            end
            head <= adv(head, rd_slots);
            tail <= adv(tail, wr_slots);
            occ  <= occ + CW'(wr_n) - CW'(rd_n);
            free <= free - wr_slots + rd_slots;
        end
    end

    // R5
    free_bound_chk: assert property (@(posedge clk) disable iff (rst)
        int'(free) <= SLOTS);

    // R5
    empty_free_chk: assert property (@(posedge clk) disable iff (rst)
        (occ == '0) |-> (free == CW'(SLOTS)));
endmodule

// File: rtl/uop_queue.sv
module uop_queue
    import uq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int TAG_W = 8,
    parameter int UOP_W = 4,
    parameter int LANES = 4,
    localparam int SLOTS = (DEPTH == 0) ? 1 : DEPTH,
    localparam int PW    = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int CW    = $clog2(SLOTS + 1),
    localparam int LCW   = $clog2(LANES + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   delay_mode,
    input  logic [LCW-1:0]         intake_cap,
    input  logic [LANES-1:0]       in_valid,
    input  logic [LANES*TAG_W-1:0] in_tag,
    input  logic [LANES*UOP_W-1:0] in_uops,
    output logic [LCW-1:0]         in_taken,
    output logic [LANES-1:0]       out_valid,
    output logic [LANES*TAG_W-1:0] out_tag,
    output logic [LANES*CW-1:0]    out_uops,
    input  logic [LCW-1:0]         out_take,
    output logic [CW-1:0]          free_slots,
    output logic                   busy
);
    logic [LANES*TAG_W-1:0] st_tag;
    logic [LANES*CW-1:0]    st_norm, lane_norm;
    logic [LCW-1:0]         st_n, st_take, acc_n, out_n, take_all;
    logic [CW-1:0]          st_drain, avail, acc_slots, drain_all, free_nx;
    fill_e                  fill_q, fill_d;

    // stored instructions that leave this cycle
    always_comb begin
        st_take  = (out_take < st_n) ? out_take : st_n;
        st_drain = '0;
        for (int k = 0; k < LANES; k++)
            if (k < int'(st_take)) st_drain = st_drain + st_norm[k*CW +: CW];
    end

    assign avail = delay_mode ? (free_slots + st_drain) : free_slots;

    uq_intake #(.LANES(LANES), .UOP_W(UOP_W), .SLOTS(SLOTS), .CW(CW), .LCW(LCW)) u_intake (
        .lane_vld (in_valid),
        .lane_uops(in_uops),
        .cap      (intake_cap),
        .avail    (avail),
        .lane_norm(lane_norm),
        .acc_n    (acc_n),
        .acc_slots(acc_slots)
    );

    // output lanes: stored heads, then same-cycle arrivals when transparent
    always_comb begin
        out_tag  = '0;
        out_uops = '0;
        out_n    = '0;
        for (int k = 0; k < LANES; k++) begin
            if (k < int'(st_n)) begin
                out_tag[k*TAG_W +: TAG_W] = st_tag[k*TAG_W +: TAG_W];
                out_uops[k*CW +: CW]      = st_norm[k*CW +: CW];
                out_n = out_n + LCW'(1);
            end else if (!delay_mode && (k - int'(st_n)) < int'(acc_n)) begin
                out_tag[k*TAG_W +: TAG_W] = in_tag[(k - int'(st_n))*TAG_W +: TAG_W];
                out_uops[k*CW +: CW]      = lane_norm[(k - int'(st_n))*CW +: CW];
                out_n = out_n + LCW'(1);
            end
        end
        for (int k = 0; k < LANES; k++) out_valid[k] = (k < int'(out_n));
    end

    // total drain including arrivals passed straight through
    always_comb begin
        take_all  = (out_take < out_n) ? out_take : out_n;
        drain_all = st_drain;
        for (int j = 0; j < LANES; j++)
            if (j < int'(acc_n) && (int'(st_n) + j) < int'(take_all))
                drain_all = drain_all + lane_norm[j*CW +: CW];
    end

    assign in_taken = acc_n;

    uq_store #(.SLOTS(SLOTS), .TAG_W(TAG_W), .LANES(LANES), .CW(CW), .LCW(LCW), .PW(PW)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_n    (acc_n),
        .wr_tag  (in_tag),
        .wr_norm (lane_norm),
        .wr_slots(acc_slots),
        .rd_n    (take_all),
        .rd_slots(drain_all),
        .st_tag  (st_tag),
        .st_norm (st_norm),
        .st_n    (st_n),
        .free    (free_slots)
    );

    // occupancy state machine
    assign free_nx = free_slots - acc_slots + drain_all;

    always_comb begin
        if (free_nx == CW'(SLOTS))  fill_d = FILL_EMPTY;
        else if (free_nx == '0)     fill_d = FILL_FULL;
        else                        fill_d = FILL_PART;
    end

    always_ff @(posedge clk) begin
        if (rst) fill_q <= FILL_EMPTY;
        else     fill_q <= fill_d;
    end

    always_comb begin
        unique case (fill_q)
            FILL_EMPTY: busy = 1'b0;
            FILL_PART:  busy = 1'b1;
            FILL_FULL:  busy = 1'b1;
            default:    busy = 1'b1;
        endcase
    end

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (free_slots == CW'(SLOTS) && !busy));

    // R4
    cap_limit_chk: assert property (@(posedge clk) disable iff (rst)
        (intake_cap != '0) |-> (in_taken <= intake_cap));

    // R6
    out_order_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid & (out_valid + LANES'(1))) == '0);

    // R8
    delay_hold_chk: assert property (@(posedge clk) disable iff (rst)
        delay_mode |-> ($countones(out_valid) <= int'(st_n)));

    // R9
    busy_match_chk: assert property (@(posedge clk) disable iff (rst)
        busy == (free_slots != CW'(SLOTS)));

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        // R3
        lead_lane_chk: assert property (@(posedge clk) disable iff (rst)
            (LCW'(k) < in_taken) |-> in_valid[k]);
    end
endmodule

// File: tb/sim_uop_queue.sv
`timescale 1ns/1ps
module sim_uop_queue;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        delay_mode = 1'b0;
    logic [2:0]  intake_cap = '0;
    logic [3:0]  in_valid = '0;
    logic [31:0] in_tag = '0;
    logic [15:0] in_uops = '0;
    logic [2:0]  out_take = '0;

    logic [2:0]  in_taken;
    logic [3:0]  out_valid;
    logic [31:0] out_tag;
    logic [15:0] out_uops;
    logic [3:0]  free_slots;
    logic        busy;

    logic [2:0]  s_taken;
    logic [3:0]  s_valid;
    logic [31:0] s_tag;
    logic [3:0]  s_uops;
    logic [0:0]  s_free;
    logic        s_busy;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    uop_queue #(.DEPTH(8)) u0 (
        .clk(clk), .rst(rst), .delay_mode(delay_mode), .intake_cap(intake_cap),
        .in_valid(in_valid), .in_tag(in_tag), .in_uops(in_uops), .in_taken(in_taken),
        .out_valid(out_valid), .out_tag(out_tag), .out_uops(out_uops), .out_take(out_take),
        .free_slots(free_slots), .busy(busy)
    );

    // zero depth instance, used only for R10
    uop_queue #(.DEPTH(0)) u1 (
        .clk(clk), .rst(rst), .delay_mode(delay_mode), .intake_cap(intake_cap),
        .in_valid(in_valid), .in_tag(in_tag), .in_uops(in_uops), .in_taken(s_taken),
        .out_valid(s_valid), .out_tag(s_tag), .out_uops(s_uops), .out_take(out_take),
        .free_slots(s_free), .busy(s_busy)
    );

    typedef struct packed {
        logic        md;
        logic [2:0]  cap;
        logic [3:0]  vld;
        logic [15:0] uops;   // lane0 in low nibble
        logic [2:0]  take;
        logic [2:0]  eacc;
        logic [2:0]  eout;
        logic [3:0]  efree;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 3'd0, 4'hF, 16'h1111, 3'd0, 3'd4, 3'd0, 4'd4},
        '{1'b1, 3'd0, 4'hF, 16'h1122, 3'd2, 3'd4, 3'd4, 4'd0},
        '{1'b1, 3'd0, 4'h1, 16'h0001, 3'd0, 3'd0, 3'd4, 4'd0},
        '{1'b1, 3'd2, 4'hF, 16'h1111, 3'd4, 3'd2, 3'd4, 4'd4},
        '{1'b0, 3'd0, 4'hF, 16'h1123, 3'd4, 3'd1, 3'd4, 4'd5},
        '{1'b0, 3'd0, 4'h3, 16'h0011, 3'd3, 3'd2, 3'd3, 4'd8},
        '{1'b0, 3'd1, 4'hF, 16'h1111, 3'd1, 3'd1, 3'd1, 4'd8},
        '{1'b0, 3'd0, 4'h3, 16'h00F0, 3'd0, 3'd1, 3'd1, 4'd7},
        '{1'b0, 3'd0, 4'h2, 16'h0010, 3'd1, 3'd0, 3'd1, 4'd8},
        '{1'b0, 3'd0, 4'h1, 16'h000F, 3'd0, 3'd1, 3'd1, 4'd0},
        '{1'b0, 3'd0, 4'h1, 16'h0001, 3'd1, 3'd0, 3'd1, 4'd8},
        '{1'b1, 3'd0, 4'h1, 16'h0001, 3'd0, 3'd1, 3'd0, 4'd7},
        '{1'b1, 3'd0, 4'h0, 16'h0000, 3'd4, 3'd0, 3'd1, 4'd8}
    };

    function automatic string acc_req(input int i);
        case (i)
            1, 11:    return "R8";
            3, 6:     return "R4";
            4, 5, 10: return "R7";
            7, 9:     return "R2";
            12:       return "R6";
            default:  return "R3";
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(input logic md, input logic [2:0] cp, input logic [3:0] vl,
                         input logic [15:0] up, input logic [31:0] tg, input logic [2:0] tk);
        @(negedge clk);
        delay_mode = md; intake_cap = cp; in_valid = vl;
        in_uops = up; in_tag = tg; out_take = tk;
        #1;
    endtask

    task automatic idle();
        drive(1'b0, 3'd0, 4'h0, 16'h0, 32'h0, 3'd0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = '0; out_take = '0;
        repeat (2) @(posedge clk);
        #1;
        rst = 1'b0;
    endtask

    initial begin
        #1600000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        idle();
        // R1 reset state
        chk(free_slots == 4'd8, "R1", free_slots, 8);
        chk(busy == 1'b0, "R1", busy, 0);
        chk(out_valid == 4'h0, "R1", out_valid, 0);

        // vector table
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].md, VEC[i].cap, VEC[i].vld, VEC[i].uops,
                  {8'(i*4+3), 8'(i*4+2), 8'(i*4+1), 8'(i*4)}, VEC[i].take);
            chk(in_taken == VEC[i].eacc, acc_req(i), in_taken, VEC[i].eacc);
            chk($countones(out_valid) == int'(VEC[i].eout),
                VEC[i].md ? "R8" : "R7", $countones(out_valid), VEC[i].eout);
            @(posedge clk);
            #1;
            chk(free_slots == VEC[i].efree, "R5", free_slots, VEC[i].efree);
            chk(busy == (VEC[i].efree != 4'd8), "R9", busy, VEC[i].efree != 4'd8);
        end

        // R6 order, tags and normalized costs after a delayed arrival
        do_reset();
        drive(1'b1, 3'd0, 4'h3, 16'h0030, {16'h0, 8'hB2, 8'hA1}, 3'd0);
        chk(in_taken == 3'd2, "R3", in_taken, 2);
        chk(out_valid == 4'h0, "R8", out_valid, 0);
        drive(1'b1, 3'd0, 4'h0, 16'h0, 32'h0, 3'd0);
        chk(out_valid == 4'h3, "R6", out_valid, 3);
        chk(out_tag[7:0] == 8'hA1, "R6", out_tag[7:0], 8'hA1);
        chk(out_tag[15:8] == 8'hB2, "R6", out_tag[15:8], 8'hB2);
        chk(out_uops[3:0] == 4'd1, "R2", out_uops[3:0], 1);
        chk(out_uops[7:4] == 4'd3, "R2", out_uops[7:4], 3);
        drive(1'b1, 3'd0, 4'h0, 16'h0, 32'h0, 3'd1);
        @(posedge clk);
        #1;
        chk(free_slots == 4'd5, "R6", free_slots, 5);
        chk(out_tag[7:0] == 8'hB2, "R6", out_tag[7:0], 8'hB2);

        // R1 reset while holding data
        drive(1'b1, 3'd0, 4'hF, 16'h1111, 32'h0, 3'd0);
        do_reset();
        idle();
        chk(free_slots == 4'd8, "R1", free_slots, 8);
        chk(busy == 1'b0, "R1", busy, 0);
        chk(out_valid == 4'h0, "R1", out_valid, 0);

        // R10 zero depth: one slot, one instruction per cycle
        for (int c = 0; c < 3; c++) begin
            drive(1'b0, 3'd0, 4'h3, 16'h0021, {16'h0, 8'h55, 8'(8'h40 + c)}, 3'd4);
            chk(s_taken == 3'd1, "R10", s_taken, 1);
            chk(s_valid == 4'h1, "R10", s_valid, 1);
            chk(s_tag[7:0] == 8'(8'h40 + c), "R10", s_tag[7:0], 8'h40 + c);
            @(posedge clk);
            #1;
            chk(s_free == 1'b1, "R10", s_free, 1);
        end
        idle();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule